// File: doc/BRIEF.md
# Four-Lane Byte Synchronization Lock Controller

This block decides when a four-lane 8b/10b receive path may be trusted as one aligned channel. Once per byte clock, each lane presents whether it saw a comma character, whether its decoder flagged an error, whether its clock recovery reports lock, whether the byte is valid, and whether the lane's alignment sits inside the deskew window. A single state machine shared by all lanes moves from an idle unsynchronized state, through comma acquisition and a deskew check, into a synchronized state. It falls back to the idle state when any loss condition appears.

Clock-recovery lock has to be qualified before locking may start. Every lane's lock flag must stay high for a long, programmable number of byte clocks, and any drop restarts the count. Two kinds of error monitor run on every lane. A run counter catches back-to-back decode errors. A fixed-block counter catches an error density above one half. While the channel is unsynchronized, each lane shows a fixed "no sync" code on its three status outputs. At all other times those outputs carry the decoder's own flags unchanged.

Top module: `laneLockCtrl`

## Requirements
- R1: While `syncRstN` is low at a rising edge, the machine enters the unsynchronized state. It clears every counter, including lock qualification, and this takes priority over all other inputs.
- R2: The machine leaves the unsynchronized state only after every lane's `cdrLock` has been high for at least QUAL_CYCLES consecutive rising edges. A low `cdrLock` restarts that lane's count from zero.
- R3: In the unsynchronized state, with locking enabled and qualified and no loss condition present, one valid comma on any lane moves the machine to acquisition.
- R4: In acquisition, each lane counts its valid commas, starting with the one that caused entry. When every lane has reached 4, the machine moves to the deskew-check state. A valid byte with a decode error on any lane during acquisition returns it to the unsynchronized state.
- R5: In the deskew-check state, if any lane has a valid byte outside the window, the machine returns to the unsynchronized state. Otherwise, if all four lanes have a valid byte inside the window in the same cycle, it moves to the synchronized state.
- R6: From any state, a low `chLockEn` or a low `cdrLock` on any lane forces the unsynchronized state at the next edge.
- R7: Four consecutive valid bytes with decode errors on one lane force the unsynchronized state. A valid error-free byte restarts the run, and invalid bytes neither extend nor break it.
- R8: Each lane groups its valid bytes into fixed blocks of 16, counted from reset. If more than 8 bytes of a block carry decode errors, the unsynchronized state is forced when the block's last byte arrives. A block with exactly 8 errors forces nothing.
- R9: In the unsynchronized state, every lane drives ERR=1, EOF=0, KFLAG=1 (`statErr`, `statEof`, `statK`). In every other state those outputs equal `rxErrFlag`, `rxEofFlag` and `rxKFlag`.
- R10: `inSync` is high exactly when the registered state is the synchronized state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; all state changes on the rising edge |
| syncRstN | input | 1 | Synchronous active-low reset and resynchronization request |
| chLockEn | input | 1 | Channel-lock enable; low forces loss of sync |
| cdrLock | input | 4 | Per-lane clock-recovery lock flag |
| commaDet | input | 4 | Per-lane comma (K28.5) detected on this byte |
| decErr | input | 4 | Per-lane decode error on this byte |
| dataValid | input | 4 | Per-lane byte-valid strobe |
| inWindow | input | 4 | Per-lane alignment inside the deskew window |
| rxErrFlag | input | 4 | Decoder ERR status, passed through when synchronized |
| rxEofFlag | input | 4 | Decoder EOF status, passed through when synchronized |
| rxKFlag | input | 4 | Decoder KFLAG status, passed through when synchronized |
| statErr | output | 4 | Per-lane ERR status output |
| statEof | output | 4 | Per-lane EOF status output |
| statK | output | 4 | Per-lane KFLAG status output |
| inSync | output | 1 | Registered synchronized indication |

## Verification
The bench sends commas before qualification has finished, and again right after a single-cycle lock drop. A design that lets stale qualification through would enter acquisition early. The error monitors are driven with three patterns. Three errors followed by a clean byte must not drop lock, and a fourth consecutive error must. A strictly alternating pattern puts exactly eight errors in every block, so a block check with an off-by-one threshold would lose sync there. An error-error-clean pattern must trip the block check without ever tripping the run check. The remaining cases are an error during acquisition and a lane outside the window during the deskew check. Each must send the machine back to the idle state instead of letting it advance. Throughout, the status outputs are compared every cycle, which catches a wrong fixed code or passthrough leaking in the wrong state.

// File: rtl/laneLockPkg.sv
package laneLockPkg;

  typedef enum logic [1:0] {
    ST_NO_SYNC = 2'd0,
    ST_ACQ     = 2'd1,
    ST_DESKEW  = 2'd2,
    ST_LOCKED  = 2'd3
  } lockState_t;

  // control -> datapath
  typedef struct packed {
    logic commaLoad;   // entering acquisition: seed comma counters
    logic commaCount;  // in acquisition: accumulate commas
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic anyComma;
    logic allCommasDone;
    logic anyErr;
    logic anyBurst;
    logic anyRate;
    logic cdrAllUp;
    logic allQual;
  } monFlags_t;

endpackage

// File: rtl/laneMonitor.sv
module laneMonitor
  import laneLockPkg::*;
#(
  parameter int QUAL_CYCLES  = 32000,
  parameter int COMMA_TARGET = 4,
  parameter int BURST_LIMIT  = 4,
  parameter int BLOCK_LEN    = 16,
  parameter int RATE_LIMIT   = 8
) (
  input  logic        clk,
  input  logic        syncRstN,
  input  logic        comma,
  input  logic        decErr,
  input  logic        cdrLock,
  input  logic        dataValid,
  input  ctrlStrobe_t strobe,
  output logic        commaHit,
  output logic        commaDone,
  output logic        errHit,
  output logic        burstHit,
  output logic        rateHit,
  output logic        cdrQual
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int KW = $clog2(COMMA_TARGET + 1);
  localparam int CW = $clog2(BURST_LIMIT + 1);
  localparam int BW = (BLOCK_LEN > 2) ? $clog2(BLOCK_LEN) : 1;
  localparam int EW = $clog2(BLOCK_LEN + 1);

  localparam logic [QW-1:0] QUAL_MAX   = QW'(QUAL_CYCLES);
  localparam logic [KW-1:0] COMMA_MAX  = KW'(COMMA_TARGET);
  localparam logic [CW-1:0] BURST_MAX  = CW'(BURST_LIMIT);
  localparam logic [CW-1:0] BURST_PRE  = CW'(BURST_LIMIT - 1);
  localparam logic [BW-1:0] BLOCK_LAST = BW'(BLOCK_LEN - 1);
  localparam logic [EW:0]   RATE_MAX   = (EW+1)'(RATE_LIMIT);

  logic [QW-1:0] qualCnt;
  logic [KW-1:0] commaCnt, commaNext;
  logic [CW-1:0] burstCnt;
  logic [BW-1:0] byteIdx;
  logic [EW-1:0] blkErr;
  logic [EW:0]   blkSum;
  logic          blockEnd;

  assign commaHit = dataValid & comma;
  assign errHit   = dataValid & decErr;
  assign cdrQual  = (qualCnt == QUAL_MAX);

  // lock qualification timer
  always_ff @(posedge clk) begin
    if (!syncRstN || !cdrLock) qualCnt <= '0;
    else if (qualCnt != QUAL_MAX) qualCnt <= qualCnt + 1'b1;
  end

  // comma accumulation during acquisition
  always_comb begin
    commaNext = '0;
    if (strobe.commaLoad) begin
      commaNext = commaHit ? KW'(1) : '0;
    end else if (strobe.commaCount) begin
      commaNext = (commaHit && commaCnt < COMMA_MAX) ? commaCnt + 1'b1 : commaCnt;
    end
  end
  assign commaDone = (commaNext >= COMMA_MAX);

  always_ff @(posedge clk) begin
    if (!syncRstN) commaCnt <= '0;
    else           commaCnt <= commaNext;
  end

  // run of consecutive decode errors
  always_ff @(posedge clk) begin
    if (!syncRstN) begin
      burstCnt <= '0;
    end else if (dataValid) begin
      if (!decErr)                    burstCnt <= '0;
      else if (burstCnt != BURST_MAX) burstCnt <= burstCnt + 1'b1;
    end
  end
  assign burstHit = errHit && (burstCnt >= BURST_PRE);

  // fixed-block error density
  assign blockEnd = dataValid && (byteIdx == BLOCK_LAST);
  assign blkSum   = {1'b0, blkErr} + {{EW{1'b0}}, errHit};
  assign rateHit  = blockEnd && (blkSum > RATE_MAX);

  always_ff @(posedge clk) begin
    if (!syncRstN) begin
      byteIdx <= '0;
      blkErr  <= '0;
    end else if (dataValid) begin
      if (byteIdx == BLOCK_LAST) begin
        byteIdx <= '0;
        blkErr  <= '0;
      end else begin
        byteIdx <= byteIdx + 1'b1;
        blkErr  <= blkSum[EW-1:0];
      end
    end
  end

  // R2: qualification is only ever held after a cycle of lock
  a_r2_qual_after_lock: assert property (@(posedge clk) disable iff (!syncRstN)
    cdrQual |-> $past(cdrLock));

  generate
    if (BURST_LIMIT > 1) begin : g_burstChk
      // R7: a clean valid byte breaks the run
      a_r7_clean_breaks_run: assert property (@(posedge clk) disable iff (!syncRstN)
        (dataValid && !decErr) |=> !burstHit);
    end
  endgenerate

endmodule

// File: rtl/laneLockDatapath.sv
module laneLockDatapath
  import laneLockPkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int QUAL_CYCLES  = 32000,
  parameter int COMMA_TARGET = 4,
  parameter int BURST_LIMIT  = 4,
  parameter int BLOCK_LEN    = 16,
  parameter int RATE_LIMIT   = 8
) (
  input  logic                 clk,
  input  logic                 syncRstN,
  input  logic [NUM_LANES-1:0] commaDet,
  input  logic [NUM_LANES-1:0] decErr,
  input  logic [NUM_LANES-1:0] cdrLock,
  input  logic [NUM_LANES-1:0] dataValid,
  input  ctrlStrobe_t          strobe,
  output monFlags_t            flags
);

  logic [NUM_LANES-1:0] commaHit, commaDone, errHit, burstHit, rateHit, cdrQual;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      laneMonitor #(
        .QUAL_CYCLES (QUAL_CYCLES),
        .COMMA_TARGET(COMMA_TARGET),
        .BURST_LIMIT (BURST_LIMIT),
        .BLOCK_LEN   (BLOCK_LEN),
        .RATE_LIMIT  (RATE_LIMIT)
      ) u_mon (
        .clk      (clk),
        .syncRstN (syncRstN),
        .comma    (commaDet[g]),
        .decErr   (decErr[g]),
        .cdrLock  (cdrLock[g]),
        .dataValid(dataValid[g]),
        .strobe   (strobe),
        .commaHit (commaHit[g]),
        .commaDone(commaDone[g]),
        .errHit   (errHit[g]),
        .burstHit (burstHit[g]),
        .rateHit  (rateHit[g]),
        .cdrQual  (cdrQual[g])
      );
    end
  endgenerate

  always_comb begin
    flags.anyComma      = |commaHit;
    flags.allCommasDone = &commaDone;
    flags.anyErr        = |errHit;
    flags.anyBurst      = |burstHit;
    flags.anyRate       = |rateHit;
    flags.cdrAllUp      = &cdrLock;
    flags.allQual       = &cdrQual;
  end

endmodule

// File: rtl/laneLockControl.sv
module laneLockControl
  import laneLockPkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 syncRstN,
  input  logic                 chLockEn,
  input  logic [NUM_LANES-1:0] dataValid,
  input  logic [NUM_LANES-1:0] inWindow,
  input  logic [NUM_LANES-1:0] rxErrFlag,
  input  logic [NUM_LANES-1:0] rxEofFlag,
  input  logic [NUM_LANES-1:0] rxKFlag,
  input  monFlags_t            flags,
  output ctrlStrobe_t          strobe,
  output logic [NUM_LANES-1:0] statErr,
  output logic [NUM_LANES-1:0] statEof,
  output logic [NUM_LANES-1:0] statK,
  output logic                 inSync
);

  lockState_t state, stateNext;
  logic forceLoss, anyOutside, allInside, noSync;

  assign forceLoss  = !syncRstN || !chLockEn || !flags.cdrAllUp
                      || flags.anyBurst || flags.anyRate;
  assign anyOutside = |(dataValid & ~inWindow);
  assign allInside  = &(dataValid & inWindow);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_NO_SYNC: begin
        if (!forceLoss && flags.allQual && flags.anyComma) begin
          stateNext        = ST_ACQ;
          strobe.commaLoad = 1'b1;
        end
      end
      ST_ACQ: begin
        strobe.commaCount = 1'b1;
        if (flags.anyErr)             stateNext = ST_NO_SYNC;
        else if (flags.allCommasDone) stateNext = ST_DESKEW;
      end
      ST_DESKEW: begin
        if (anyOutside)     stateNext = ST_NO_SYNC;
        else if (allInside) stateNext = ST_LOCKED;
      end
      ST_LOCKED: stateNext = ST_LOCKED;
      default:   stateNext = ST_NO_SYNC;
    endcase
    if (forceLoss) stateNext = ST_NO_SYNC;
  end

  always_ff @(posedge clk) begin
    if (!syncRstN) state <= ST_NO_SYNC;
    else           state <= stateNext;
  end

  assign noSync  = (state == ST_NO_SYNC);
  assign statErr = noSync ? {NUM_LANES{1'b1}} : rxErrFlag;
  assign statEof = noSync ? {NUM_LANES{1'b0}} : rxEofFlag;
  assign statK   = noSync ? {NUM_LANES{1'b1}} : rxKFlag;
  assign inSync  = (state == ST_LOCKED);

  // R1: reset lands in the idle state
  a_r1_reset_idle: assert property (@(posedge clk)
    !syncRstN |=> (state == ST_NO_SYNC));

  // R6: enable or lock loss forces idle
  a_r6_force_idle: assert property (@(posedge clk) disable iff (!syncRstN)
    (!chLockEn || !flags.cdrAllUp) |=> (state == ST_NO_SYNC));

  // R3: no comma, no exit from idle
  a_r3_exit_needs_comma: assert property (@(posedge clk) disable iff (!syncRstN)
    (state == ST_NO_SYNC && !flags.anyComma) |=> (state == ST_NO_SYNC));

  // R2: no exit from idle before qualification
  a_r2_exit_needs_qual: assert property (@(posedge clk) disable iff (!syncRstN)
    (state == ST_NO_SYNC && !flags.allQual) |=> (state == ST_NO_SYNC));

  // R5: a lane outside the window aborts the deskew check
  a_r5_window_abort: assert property (@(posedge clk) disable iff (!syncRstN)
    (state == ST_DESKEW && anyOutside) |=> (state == ST_NO_SYNC));

  // R10: sync rises only after all lanes were valid inside the window
  a_r10_rise_needs_window: assert property (@(posedge clk) disable iff (!syncRstN)
    $rose(inSync) |-> $past(&(dataValid & inWindow)));

endmodule

// File: rtl/laneLockCtrl.sv
module laneLockCtrl
  import laneLockPkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int QUAL_CYCLES  = 32000,
  parameter int COMMA_TARGET = 4,
  parameter int BURST_LIMIT  = 4,
  parameter int BLOCK_LEN    = 16,
  parameter int RATE_LIMIT   = 8
) (
  input  logic                 clk,
  input  logic                 syncRstN,
  input  logic                 chLockEn,
  input  logic [NUM_LANES-1:0] cdrLock,
  input  logic [NUM_LANES-1:0] commaDet,
  input  logic [NUM_LANES-1:0] decErr,
  input  logic [NUM_LANES-1:0] dataValid,
  input  logic [NUM_LANES-1:0] inWindow,
  input  logic [NUM_LANES-1:0] rxErrFlag,
  input  logic [NUM_LANES-1:0] rxEofFlag,
  input  logic [NUM_LANES-1:0] rxKFlag,
  output logic [NUM_LANES-1:0] statErr,
  output logic [NUM_LANES-1:0] statEof,
  output logic [NUM_LANES-1:0] statK,
  output logic                 inSync
);

  ctrlStrobe_t strobe;
  monFlags_t   flags;

  laneLockDatapath #(
    .NUM_LANES   (NUM_LANES),
    .QUAL_CYCLES (QUAL_CYCLES),
    .COMMA_TARGET(COMMA_TARGET),
    .BURST_LIMIT (BURST_LIMIT),
    .BLOCK_LEN   (BLOCK_LEN),
    .RATE_LIMIT  (RATE_LIMIT)
  ) u_dp (
    .clk      (clk),
    .syncRstN (syncRstN),
    .commaDet (commaDet),
    .decErr   (decErr),
    .cdrLock  (cdrLock),
    .dataValid(dataValid),
    .strobe   (strobe),
    .flags    (flags)
  );

  laneLockControl #(
    .NUM_LANES(NUM_LANES)
  ) u_ctl (
    .clk      (clk),
    .syncRstN (syncRstN),
    .chLockEn (chLockEn),
    .dataValid(dataValid),
    .inWindow (inWindow),
    .rxErrFlag(rxErrFlag),
    .rxEofFlag(rxEofFlag),
    .rxKFlag  (rxKFlag),
    .flags    (flags),
    .strobe   (strobe),
    .statErr  (statErr),
    .statEof  (statEof),
    .statK    (statK),
    .inSync   (inSync)
  );

endmodule

// File: tb/laneLockCtrl_tb.sv
`timescale 1ns/1ps
module laneLockCtrl_tb;

  localparam int QUAL = 40;

  logic clk = 1'b0;
  logic syncRstN = 1'b0;
  logic chLockEn = 1'b0;
  logic [3:0] cdrLock = '0, commaDet = '0, decErr = '0, dataValid = '0, inWindow = '0;
  logic [3:0] rxErrFlag = '0, rxEofFlag = '0, rxKFlag = '0;
  logic [3:0] statErr, statEof, statK;
  logic inSync;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  laneLockCtrl #(.QUAL_CYCLES(QUAL)) u_dut (
    .clk(clk), .syncRstN(syncRstN), .chLockEn(chLockEn), .cdrLock(cdrLock),
    .commaDet(commaDet), .decErr(decErr), .dataValid(dataValid), .inWindow(inWindow),
    .rxErrFlag(rxErrFlag), .rxEofFlag(rxEofFlag), .rxKFlag(rxKFlag),
    .statErr(statErr), .statEof(statEof), .statK(statK), .inSync(inSync)
  );

  // behavioural reference: 0 idle, 1 acquiring, 2 deskew check, 3 synchronized
  int mState = 0;
  int mQual[4], mComma[4], mRun[4], mIdx[4], mBlk[4];

  initial for (int i = 0; i < 4; i++) begin
    mQual[i] = 0; mComma[i] = 0; mRun[i] = 0; mIdx[i] = 0; mBlk[i] = 0;
  end

  always @(posedge clk) begin : refModel
    int nxt;
    int ncc[4];
    bit lose, anyC, anyE, allQ, allD, anyOut, allIn;
    lose = !syncRstN || !chLockEn || (cdrLock != 4'hF);
    anyC = 0; anyE = 0; allQ = 1; anyOut = 0; allIn = 1; allD = 1;
    for (int i = 0; i < 4; i++) begin
      ncc[i] = 0;
      if (dataValid[i] && commaDet[i]) anyC = 1;
      if (dataValid[i] && decErr[i]) begin
        anyE = 1;
        if (mRun[i] >= 3) lose = 1;
      end
      if (dataValid[i] && mIdx[i] == 15 && (mBlk[i] + int'(decErr[i])) > 8) lose = 1;
      if (mQual[i] < QUAL) allQ = 0;
      if (dataValid[i] && !inWindow[i]) anyOut = 1;
      if (!(dataValid[i] && inWindow[i])) allIn = 0;
    end
    nxt = mState;
    case (mState)
      0: if (!lose && allQ && anyC) begin
           nxt = 1;
           for (int i = 0; i < 4; i++) ncc[i] = (dataValid[i] && commaDet[i]) ? 1 : 0;
         end
      1: begin
           for (int i = 0; i < 4; i++) begin
             ncc[i] = mComma[i] + ((dataValid[i] && commaDet[i] && mComma[i] < 4) ? 1 : 0);
             if (ncc[i] < 4) allD = 0;
           end
           if (anyE) nxt = 0;
           else if (allD) nxt = 2;
         end
      2: if (anyOut) nxt = 0; else if (allIn) nxt = 3;
      default: ;
    endcase
    if (lose) nxt = 0;
    if (!syncRstN) begin
      mState = 0;
      for (int i = 0; i < 4; i++) begin
        mQual[i] = 0; mComma[i] = 0; mRun[i] = 0; mIdx[i] = 0; mBlk[i] = 0;
      end
    end else begin
      mState = nxt;
      for (int i = 0; i < 4; i++) begin
        mComma[i] = ncc[i];
        mQual[i] = cdrLock[i] ? ((mQual[i] < QUAL) ? mQual[i] + 1 : QUAL) : 0;
        if (dataValid[i]) begin
          mRun[i] = decErr[i] ? ((mRun[i] < 4) ? mRun[i] + 1 : 4) : 0;
          if (mIdx[i] == 15) begin mIdx[i] = 0; mBlk[i] = 0; end
          else begin mIdx[i] = mIdx[i] + 1; mBlk[i] = mBlk[i] + int'(decErr[i]); end
        end
      end
    end
  end

  task automatic check4(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference (R9, R10)
  task automatic compareAll();
    bit idle;
    idle = (mState == 0);
    check4(curReq, "inSync R10", {3'b0, inSync}, {3'b0, mState == 3});
    check4(curReq, "statErr R9", statErr, idle ? 4'hF : rxErrFlag);
    check4(curReq, "statEof R9", statEof, idle ? 4'h0 : rxEofFlag);
    check4(curReq, "statK R9",   statK,   idle ? 4'hF : rxKFlag);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      compareAll();
    end
  endtask

  task automatic idleIn();
    dataValid = '0; commaDet = '0; decErr = '0; inWindow = '0;
  endtask

  // one valid byte on every lane
  task automatic sendByte(input logic [3:0] c, input logic [3:0] e, input logic [3:0] w);
    dataValid = 4'hF; commaDet = c; decErr = e; inWindow = w;
    tick(1);
  endtask

  task automatic expectSync(input string req, input bit exp);
    check4(req, "explicit inSync", {3'b0, inSync}, {3'b0, exp});
  endtask

  task automatic doLock();
    for (int k = 0; k < 4; k++) sendByte(4'hF, 4'h0, 4'hF);
    sendByte(4'h0, 4'h0, 4'hF);
    idleIn();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rxErrFlag = 4'b0110; rxEofFlag = 4'b1010; rxKFlag = 4'b0011;
    // R1: reset state
    curReq = "R1";
    tick(3);
    check4("R1", "reset statErr/statEof/statK", {statErr[0], statEof[0], statK[0], inSync}, 4'b1010);
    syncRstN = 1'b1; chLockEn = 1'b1; cdrLock = 4'hF;

    // R2: commas before qualification are ignored
    curReq = "R2";
    tick(5);
    doLock();
    expectSync("R2", 1'b0);
    check4("R2", "still idle code", statEof, 4'h0);
    tick(QUAL);

    // R3: one comma enters acquisition (passthrough visible)
    curReq = "R3";
    sendByte(4'b0100, 4'h0, 4'hF);
    check4("R3", "acq passthrough statEof", statEof, rxEofFlag);
    idleIn();
    tick(2);

    // R4: error during acquisition drops back
    curReq = "R4";
    sendByte(4'h0, 4'b0001, 4'hF);
    check4("R4", "error in acq -> idle code", statErr, 4'hF);
    idleIn();
    tick(2);

    // R4/R5: full lock
    curReq = "R5";
    doLock();
    expectSync("R5", 1'b1);
    tick(2);

    // R7: three errors then clean keeps lock; four drop it
    curReq = "R7";
    for (int k = 0; k < 3; k++) sendByte(4'h0, 4'b0100, 4'hF);
    sendByte(4'h0, 4'h0, 4'hF);
    expectSync("R7", 1'b1);
    for (int k = 0; k < 3; k++) sendByte(4'h0, 4'b0100, 4'hF);
    expectSync("R7", 1'b1);
    sendByte(4'h0, 4'b0100, 4'hF);
    expectSync("R7", 1'b0);
    idleIn();
    tick(2);

    // R8: alternating errors give exactly 8 per block -> stays locked
    curReq = "R8";
    doLock();
    for (int k = 0; k < 40; k++) sendByte(4'h0, (k % 2 == 0) ? 4'b0010 : 4'h0, 4'hF);
    expectSync("R8", 1'b1);
    // error-error-clean exceeds half without a run of four
    for (int k = 0; k < 18; k++) sendByte(4'h0, (k % 3 != 2) ? 4'b0010 : 4'h0, 4'hF);
    expectSync("R8", 1'b0);
    idleIn();
    tick(2);

    // R5: a lane outside the window aborts the deskew check
    curReq = "R5";
    for (int k = 0; k < 4; k++) sendByte(4'hF, 4'h0, 4'hF);
    sendByte(4'h0, 4'h0, 4'b1011);
    expectSync("R5", 1'b0);
    sendByte(4'h0, 4'h0, 4'hF);
    expectSync("R5", 1'b0);
    idleIn();
    tick(2);

    // R6: enable low drops lock
    curReq = "R6";
    doLock();
    expectSync("R6", 1'b1);
    chLockEn = 1'b0;
    tick(1);
    expectSync("R6", 1'b0);
    chLockEn = 1'b1;
    tick(2);

    // R6/R2: a one-cycle lock drop loses sync and restarts qualification
    doLock();
    expectSync("R6", 1'b1);
    cdrLock = 4'b0111;
    tick(1);
    expectSync("R6", 1'b0);
    cdrLock = 4'hF;
    curReq = "R2";
    doLock();
    expectSync("R2", 1'b0);
    tick(QUAL);
    doLock();
    expectSync("R2", 1'b1);

    // R1: sync reset while locked
    curReq = "R1";
    syncRstN = 1'b0;
    tick(1);
    expectSync("R1", 1'b0);
    syncRstN = 1'b1;
    doLock();
    expectSync("R1", 1'b0);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule